// File: doc/BRIEF.md
# BCD Real-Time Clock Counter Core

This block keeps calendar time as seven packed-BCD bytes: seconds, minutes, hours, day of month, month, weekday and two-digit year. A built-in prescaler counts pulses of a 32.768 kHz enable input and produces one advance of the time chain per second. Carries ripple from seconds up to the year inside the same clock cycle.

The hours byte has two layouts, chosen by its top bit. One layout is a 24-hour count. The other is a 12-hour count with a PM flag. The top bit of the seconds byte is a halt flag that freezes the prescaler and every counter.

A parallel load port lets a register front end overwrite any one byte per cycle. Writing the seconds byte restarts the sub-second prescaler. All seven bytes are visible at the outputs at all times.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the bytes read seconds 0x00, minutes 0x00, hours 0x00 (24-hour layout), day 0x01, month 0x01, weekday 0x01, year 0x00, and the prescaler count is zero.
- R2: The seconds advance once per DIV cycles in which `tick_en` is high (DIV defaults to 32768). Cycles with `tick_en` low do not count. The advance lands on the clock edge of the DIV-th enabled cycle.
- R3: While seconds bit 7 is 1, the prescaler and all seven bytes hold their values. Loading seconds with bit 7 at 0 restarts counting.
- R4: Loading the seconds byte (`ld_sel` = 0) sets the prescaler count to zero. No advance happens in that cycle, even if the count had reached its end.
- R5: Seconds and minutes count 00 to 59 in BCD. When seconds wraps, minutes advance in the same cycle, and when minutes also wraps, hours advance in that same cycle.
- R6: With hours bit 7 at 0, hours count 00 to 23 in BCD, and bit 5 holds the tens digit 2. The step from 23 to 00 produces a day carry.
- R7: With hours bit 7 at 1, bits 4:0 hold 12, 01 … 11 in BCD and bit 5 is PM (1 = PM). Going from 11 to 12 toggles PM. Going from 11 PM to 12 AM produces a day carry. Going from 12 to 01 leaves PM unchanged.
- R8: On each day carry the weekday byte advances 1 to 7 and then wraps to 1.
- R9: On each day carry the day of month advances and wraps to 01 after the month's last day. The month lengths are 31, 30, or 28 for February, and February has 29 when the BCD year is a multiple of four.
- R10: When the day wraps, the month advances 01 to 12 and wraps to 01. When the month wraps, the year advances 00 to 99 and wraps to 00.
- R11: With `ld_en` high, `ld_sel` picks the byte that takes `ld_data`: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 weekday, 6 year. Code 7 changes nothing.
- R12: When a load of a byte other than seconds coincides with a one-second advance, the loaded byte takes `ld_data`. Every other byte advances, with carries computed from the values held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32.768 kHz enable pulse, one clock wide |
| ld_en | input | 1 | Load strobe for one byte |
| ld_sel | input | 3 | Byte select for the load (codes in R11) |
| ld_data | input | 8 | Value written to the selected byte |
| sec_o | output | 8 | Bit 7 halt flag, bits 6:0 BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Hours byte in 24-hour or 12-hour layout |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| wday_o | output | 8 | BCD weekday 1 to 7 |
| year_o | output | 8 | BCD year |

## Verification
The load port and the one-second advance can act in the same clock cycle. Two cases matter: a seconds load that meets a prescaler at its end count, where the load must win and the advance must be lost, and a load of another byte during a carry ripple, where only the targeted byte is replaced. The bench provokes both by letting `tick_en` run every cycle and stepping a load across each prescaler phase. A behavioural reference model of binary hours, days and months, with a flat step-then-override rule, judges every cycle.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HR   = 3'd2,
    FLD_DATE = 3'd3,
    FLD_MON  = 3'd4,
    FLD_DOW  = 3'd5,
    FLD_YR   = 3'd6,
    FLD_NONE = 3'd7
  } fld_e;

  // Two-digit BCD increment without range limit.
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // Year value (BCD) divisible by four.
  function automatic logic is_leap(input logic [BYTE_W-1:0] y);
    if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    else      return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  // Last day of a month in BCD.
  function automatic logic [BYTE_W-1:0] month_last(input logic [BYTE_W-1:0] m,
                                                   input logic [BYTE_W-1:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Hour byte after one hour, both layouts.
  function automatic logic [BYTE_W-1:0] hr_next(input logic [BYTE_W-1:0] h);
    logic [BYTE_W-1:0] t;
    if (h[7]) begin
      if (h[4:0] == 5'h12)      return {h[7:5], 5'h01};
      else if (h[4:0] == 5'h11) return {h[7:6], ~h[5], 5'h12};
      else begin
        t = bcd_inc({3'b000, h[4:0]});
        return {h[7:5], t[4:0]};
      end
    end else begin
      if (h[5:0] == 6'h23) return {h[7:6], 6'h00};
      else                 return bcd_inc(h);
    end
  endfunction

  // Hour byte that ends the day.
  function automatic logic hr_is_last(input logic [BYTE_W-1:0] h);
    if (h[7]) return h[5] && (h[4:0] == 5'h11);
    else      return h[5:0] == 6'h23;
  endfunction
endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic halt,
  input  logic clr,
  output logic sec_pulse
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          at_top;

  assign at_top    = (cnt == TOP);
  assign sec_pulse = !halt && tick_en && !clr && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (!halt && tick_en)  cnt <= at_top ? '0 : cnt + 1'b1;
  end

  // R3: halted prescaler keeps its count
  a_r3_prescale_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !clr) |=> $stable(cnt));
  // R4: a seconds load restarts the count
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  // R2: the count restarts after each second
  a_r2_pulse_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> (cnt == '0));
endmodule

// File: rtl/tk_time_chain.sv
module tk_time_chain
  import tk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_pulse,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [BYTE_W-1:0] ld_data,
  output logic [BYTE_W-1:0] sec,
  output logic [BYTE_W-1:0] mins,
  output logic [BYTE_W-1:0] hr,
  output logic              day_carry
);
  logic sec_wrap, min_wrap, hr_wrap;
  fld_e sel;

  assign sel       = fld_e'(ld_sel);
  assign sec_wrap  = (sec[6:0] == 7'h59);
  assign min_wrap  = (mins == 8'h59);
  assign hr_wrap   = hr_is_last(hr);
  assign day_carry = sec_pulse && sec_wrap && min_wrap && hr_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      mins <= 8'h00;
      hr   <= 8'h00;
    end else begin
      if (sec_pulse) begin
        sec <= sec_wrap ? 8'h00 : bcd_inc(sec);
        if (sec_wrap) begin
          mins <= min_wrap ? 8'h00 : bcd_inc(mins);
          if (min_wrap) hr <= hr_next(hr);
        end
      end
      if (ld_en) begin
        case (sel)
          FLD_SEC: sec  <= ld_data;
          FLD_MIN: mins <= ld_data;
          FLD_HR:  hr   <= ld_data;
          default: ;
        endcase
      end
    end
  end

  // R5: seconds wrap to zero
  a_r5_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && sec_wrap && !ld_en) |=> (sec == 8'h00));
  // R6: 24-hour day ends at 00
  a_r6_day_24: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !hr[7] && !ld_en) |=> (hr == 8'h00));
  // R7: PM flag flips on 11 -> 12
  a_r7_pm_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && sec_wrap && min_wrap && hr[7] && (hr[4:0] == 5'h11) && !ld_en)
      |=> (hr[5] != $past(hr[5])));
  // R3: halted time bytes hold
  a_r3_time_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[7] && !ld_en) |=> ($stable(sec) && $stable(mins) && $stable(hr)));
endmodule

// File: rtl/tk_date_chain.sv
module tk_date_chain
  import tk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_carry,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [BYTE_W-1:0] ld_data,
  output logic [BYTE_W-1:0] date,
  output logic [BYTE_W-1:0] mon,
  output logic [BYTE_W-1:0] dow,
  output logic [BYTE_W-1:0] yr
);
  logic date_wrap, mon_wrap, dow_wrap, yr_wrap;
  fld_e sel;

  assign sel       = fld_e'(ld_sel);
  assign date_wrap = (date == month_last(mon, yr));
  assign mon_wrap  = (mon == 8'h12);
  assign dow_wrap  = (dow == 8'h07);
  assign yr_wrap   = (yr == 8'h99);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      date <= 8'h01;
      mon  <= 8'h01;
      dow  <= 8'h01;
      yr   <= 8'h00;
    end else begin
      if (day_carry) begin
        dow  <= dow_wrap ? 8'h01 : bcd_inc(dow);
        date <= date_wrap ? 8'h01 : bcd_inc(date);
        if (date_wrap) begin
          mon <= mon_wrap ? 8'h01 : bcd_inc(mon);
          if (mon_wrap) yr <= yr_wrap ? 8'h00 : bcd_inc(yr);
        end
      end
      if (ld_en) begin
        case (sel)
          FLD_DATE: date <= ld_data;
          FLD_MON:  mon  <= ld_data;
          FLD_DOW:  dow  <= ld_data;
          FLD_YR:   yr   <= ld_data;
          default: ;
        endcase
      end
    end
  end

  // R8: weekday wraps from 7 to 1
  a_r8_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && dow_wrap && !ld_en) |=> (dow == 8'h01));
  // R9: leap February reaches 29
  a_r9_leap_feb: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && (mon == 8'h02) && (date == 8'h28) && is_leap(yr) && !ld_en)
      |=> (date == 8'h29));
  // R10: year wraps on new year after 99
  a_r10_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && date_wrap && mon_wrap && yr_wrap && !ld_en) |=> (yr == 8'h00));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import tk_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       ld_en,
  input  logic [2:0] ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] wday_o,
  output logic [7:0] year_o
);
  logic sec_pulse, day_carry, halt, ld_sec;

  assign halt   = sec_o[7];
  assign ld_sec = ld_en && (fld_e'(ld_sel) == FLD_SEC);

  tk_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt),
    .clr(ld_sec), .sec_pulse(sec_pulse)
  );

  tk_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .ld_en(ld_en),
    .ld_sel(ld_sel), .ld_data(ld_data), .sec(sec_o), .mins(min_o),
    .hr(hour_o), .day_carry(day_carry)
  );

  tk_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_carry(day_carry), .ld_en(ld_en),
    .ld_sel(ld_sel), .ld_data(ld_data), .date(date_o), .mon(month_o),
    .dow(wday_o), .yr(year_o)
  );

  // R4: a seconds load never coincides with an advance
  a_r4_no_pulse_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sec |-> !sec_pulse);
  // R8: weekday moves only with a day carry or a load
  a_r8_dow_only_on_day: assert property (@(posedge clk) disable iff (!rst_n)
    (!day_carry && !ld_en) |=> $stable(wday_o));
endmodule

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic ld_en = 1'b0;
  logic [2:0] ld_sel = 3'd0;
  logic [7:0] ld_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  bcd_rtc_core #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ld_en(ld_en),
    .ld_sel(ld_sel), .ld_data(ld_data), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .date_o(date_o), .month_o(month_o),
    .wday_o(wday_o), .year_o(year_o)
  );

  // Reference model: binary counters
  int m_cnt, m_s, m_mi, m_h, m_d, m_mo, m_dw, m_y;
  bit m_halt, m_12;

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] hr_byte();
    int h12;
    logic [7:0] b;
    if (!m_12) return to_bcd(m_h);
    h12 = (m_h % 12 == 0) ? 12 : m_h % 12;
    b = to_bcd(h12);
    return {1'b1, 1'b0, (m_h >= 12) ? 1'b1 : 1'b0, b[4:0]};
  endfunction
  function automatic logic [55:0] expect_vec();
    return {m_halt, 7'(to_bcd(m_s)), to_bcd(m_mi), hr_byte(), to_bcd(m_d),
            to_bcd(m_mo), to_bcd(m_dw), to_bcd(m_y)};
  endfunction

  always @(posedge clk) begin
    bit ld_s, pulse;
    if (!rst_n) begin
      m_cnt = 0; m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_dw = 1; m_y = 0;
      m_halt = 0; m_12 = 0;
    end else begin
      ld_s  = ld_en && (ld_sel == 3'd0);
      pulse = !m_halt && tick_en && (m_cnt == DIV - 1) && !ld_s;
      if (ld_s) m_cnt = 0;
      else if (!m_halt && tick_en) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
      if (pulse) begin
        m_s++;
        if (m_s == 60) begin
          m_s = 0; m_mi++;
          if (m_mi == 60) begin
            m_mi = 0; m_h++;
            if (m_h == 24) begin
              m_h = 0;
              m_dw = (m_dw == 7) ? 1 : m_dw + 1;
              m_d++;
              if (m_d > mdays(m_mo, m_y)) begin
                m_d = 1; m_mo++;
                if (m_mo > 12) begin m_mo = 1; m_y = (m_y + 1) % 100; end
              end
            end
          end
        end
      end
      if (ld_en) begin
        case (ld_sel)
          3'd0: begin m_s = from_bcd({1'b0, ld_data[6:0]}); m_halt = ld_data[7]; end
          3'd1: m_mi = from_bcd(ld_data);
          3'd2: begin
            m_12 = ld_data[7];
            if (ld_data[7])
              m_h = (from_bcd({3'b000, ld_data[4:0]}) % 12) + (ld_data[5] ? 12 : 0);
            else
              m_h = from_bcd({2'b00, ld_data[5:0]});
          end
          3'd3: m_d = from_bcd(ld_data);
          3'd4: m_mo = from_bcd(ld_data);
          3'd5: m_dw = from_bcd(ld_data);
          3'd6: m_y = from_bcd(ld_data);
          default: ;
        endcase
      end
    end
  end

  // Cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    logic [55:0] got, exp;
    if (cmp_on && rst_n) begin
      got = {sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o};
      exp = expect_vec();
      n_chk++;
      if (got !== exp) begin
        n_fail++;
        $display("FAIL %s model compare: got %h expected %h", cur_req, got, exp);
      end
    end
  end

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s direct: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(int n, bit te);
    for (int i = 0; i < n; i++) begin
      tick_en = te;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic load(logic [2:0] s, logic [7:0] d, bit te);
    ld_en = 1'b1; ld_sel = s; ld_data = d; tick_en = te;
    @(negedge clk);
    ld_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] mi, logic [7:0] s);
    load(3'd2, h, 1'b0);
    load(3'd1, mi, 1'b0);
    load(3'd0, s, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [55:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1", sec_o, 8'h00); chk("R1", min_o, 8'h00); chk("R1", hour_o, 8'h00);
    chk("R1", date_o, 8'h01); chk("R1", month_o, 8'h01);
    chk("R1", wday_o, 8'h01); chk("R1", year_o, 8'h00);
    cmp_on = 1'b1;

    // R2 prescaler division, sparse enables
    cur_req = "R2";
    run(4, 1'b1);
    chk("R2", sec_o, 8'h01);
    for (int i = 0; i < 24; i++) run(1, (i % 3) == 0);
    chk("R2", sec_o, 8'h03);

    // R5 R6 R8 R9 R10 full rollover at year end
    cur_req = "R10";
    load(3'd3, 8'h31, 1'b0); load(3'd4, 8'h12, 1'b0);
    load(3'd6, 8'h99, 1'b0); load(3'd5, 8'h07, 1'b0);
    set_time(8'h23, 8'h59, 8'h58);
    run(8, 1'b1);
    chk("R5", sec_o, 8'h00); chk("R5", min_o, 8'h00); chk("R6", hour_o, 8'h00);
    chk("R8", wday_o, 8'h01); chk("R9", date_o, 8'h01);
    chk("R10", month_o, 8'h01); chk("R10", year_o, 8'h00);

    // R6 24-hour tens digit
    cur_req = "R6";
    set_time(8'h19, 8'h59, 8'h59);
    run(4, 1'b1);
    chk("R6", hour_o, 8'h20);

    // R7 12-hour layout
    cur_req = "R7";
    load(3'd3, 8'h15, 1'b0); load(3'd5, 8'h03, 1'b0);
    set_time(8'h91, 8'h59, 8'h59);
    run(4, 1'b1);
    chk("R7", hour_o, 8'hB2); chk("R7", date_o, 8'h15);
    set_time(8'hB1, 8'h59, 8'h59);
    run(4, 1'b1);
    chk("R7", hour_o, 8'h92); chk("R7", date_o, 8'h16); chk("R8", wday_o, 8'h04);
    set_time(8'h92, 8'h59, 8'h59);
    run(4, 1'b1);
    chk("R7", hour_o, 8'h81);

    // R9 month lengths and leap years
    cur_req = "R9";
    load(3'd6, 8'h24, 1'b0); load(3'd4, 8'h02, 1'b0); load(3'd3, 8'h28, 1'b0);
    set_time(8'h23, 8'h59, 8'h59);
    run(4, 1'b1);
    chk("R9", date_o, 8'h29);
    set_time(8'h23, 8'h59, 8'h59);
    run(4, 1'b1);
    chk("R9", date_o, 8'h01); chk("R9", month_o, 8'h03);
    load(3'd6, 8'h23, 1'b0); load(3'd4, 8'h02, 1'b0); load(3'd3, 8'h28, 1'b0);
    set_time(8'h23, 8'h59, 8'h59);
    run(4, 1'b1);
    chk("R9", date_o, 8'h01); chk("R9", month_o, 8'h03);
    load(3'd4, 8'h04, 1'b0); load(3'd3, 8'h30, 1'b0);
    set_time(8'h23, 8'h59, 8'h59);
    run(4, 1'b1);
    chk("R9", date_o, 8'h01); chk("R9", month_o, 8'h05);

    // R3 halt flag
    cur_req = "R3";
    load(3'd0, 8'h90, 1'b0);
    run(20, 1'b1);
    chk("R3", sec_o, 8'h90);
    load(3'd0, 8'h10, 1'b0);
    run(4, 1'b1);
    chk("R3", sec_o, 8'h11);

    // R4 seconds load restarts prescaler
    cur_req = "R4";
    run(2, 1'b1);
    load(3'd0, 8'h20, 1'b1);
    run(3, 1'b1);
    chk("R4", sec_o, 8'h20);
    run(1, 1'b1);
    chk("R4", sec_o, 8'h21);
    run(3, 1'b1);
    load(3'd0, 8'h40, 1'b1);
    chk("R4", sec_o, 8'h40);

    // R11 code 7 ignored
    cur_req = "R11";
    snap = {sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o};
    load(3'd7, 8'h55, 1'b0);
    n_chk++;
    if ({sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o} !== snap) begin
      n_fail++;
      $display("FAIL R11 ignored code: got %h expected %h",
               {sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o}, snap);
    end

    // R12 load meets advance
    cur_req = "R12";
    set_time(8'h05, 8'h59, 8'h59);
    run(3, 1'b1);
    load(3'd1, 8'h42, 1'b1);
    chk("R12", sec_o, 8'h00); chk("R12", min_o, 8'h42); chk("R12", hour_o, 8'h06);
    for (int ph = 0; ph < 4; ph++) begin
      set_time(8'h23, 8'h59, 8'h59);
      run(ph, 1'b1);
      load(3'd3, 8'h10, 1'b1);
      load(3'd5, 8'h02, 1'b1);
      run(5, 1'b1);
    end

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule